// File: doc/BRIEF.md
# Threshold-Paced DMA Byte FIFO

This block is the byte buffer that sits between a DMA host and a sector engine while a data transfer runs. It holds up to 16 bytes and decides when to raise the DMA request. In device-to-host transfers the sector engine pushes bytes and the host drains them with acknowledge cycles. In host-to-device transfers the host fills the buffer and the sector engine pops bytes out. Only the host is paced by the request line; the device side sees full and empty flags, and a sticky fault bit records any device access that the buffer could not serve.

A transfer begins with a one-cycle start pulse that empties the buffer and arms the request logic. It ends when terminal count is asserted. A programmed 4-bit threshold field, holding the threshold minus one, sets how full or how empty the buffer gets before the host is asked for service. The request rises and falls at different fill levels in each direction. When the buffer enable is low, the block works with a capacity of one byte, so every byte costs one request and one acknowledge.

Top module: `dma_fifo_ctrl`

## Requirements
- R1: After reset `dma_req` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `xfer_err` is 0.
- R2: Bytes leave in the order they entered. The head byte is shown on both `host_rdata` and `dev_rdata`. The capacity is 16 when `fifo_en` is 1. A push into a full buffer or a pop from an empty one changes nothing.
- R3: With `dir_to_host`=1 and `fifo_en`=1, `dma_req` goes to 1 in the cycle after the occupancy reaches max(16 − (`thr_cfg`+1), 1).
- R4: With `dir_to_host`=1, a device push that carries `dev_last`=1 raises `dma_req` in the next cycle, whatever the occupancy.
- R5: With `dir_to_host`=1, `dma_req` falls in the cycle after the buffer becomes empty, and holds its value while the occupancy lies between empty and the level of R3.
- R6: With `dir_to_host`=0, `dma_req` is 1 in the cycle after `xfer_start`. It stays 1 until the cycle after the buffer becomes full.
- R7: With `dir_to_host`=0 and `fifo_en`=1, after a full-buffer drop, `dma_req` returns in the cycle after the occupancy falls to `thr_cfg`+1 or less.
- R8: `tc` clears `dma_req` in the next cycle. No request follows until the next `xfer_start`. If both arrive in one cycle, `tc` wins.
- R9: With `fifo_en`=0 the capacity is one byte. Toward the host, the request asserts once that byte is present and drops after its acknowledge. Toward the device, the request asserts when the buffer is empty and drops once the host has written the byte.
- R10: A device push into a full buffer (`dir_to_host`=1) or a device pop from an empty buffer (`dir_to_host`=0) is ignored and sets `xfer_err`. The bit stays set until reset or the next `xfer_start`.
- R11: `xfer_start` empties the buffer, clears `xfer_err` and ignores any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: 16-byte buffering; 0: single-byte mode |
| thr_cfg | input | 4 | Threshold minus one |
| dir_to_host | input | 1 | 1: device-to-host transfer; 0: host-to-device transfer |
| xfer_start | input | 1 | One-cycle pulse on entry to the execution phase |
| tc | input | 1 | Terminal count; ends DMA activity |
| dma_req | output | 1 | DMA request to the host |
| dma_ack | input | 1 | One host byte cycle (pop toward host, push toward device) |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Head byte seen by the host |
| dev_push | input | 1 | Sector engine pushes a byte (device-to-host) |
| dev_last | input | 1 | Pushed byte is the final byte of a sector |
| dev_wdata | input | 8 | Byte pushed by the sector engine |
| dev_pop | input | 1 | Sector engine pops a byte (host-to-device) |
| dev_rdata | output | 8 | Head byte seen by the sector engine |
| fifo_full | output | 1 | Occupancy equals the current capacity |
| fifo_empty | output | 1 | Occupancy is zero |
| xfer_err | output | 1 | Sticky device-side overrun or underrun |

## Verification
A corrupted occupancy count shows up at the ports within one clock. The full and empty flags disagree with the number of bytes pushed and popped, and the request edges move from the levels that R3, R5, R6 and R7 predict. A damaged read or write pointer appears on the next pop as a head byte out of order. A stuck request register or a lost active flag shows up as a request that survives terminal count or stays low after a start pulse. Both are visible on the cycle after the event.

// File: rtl/dmaf_pkg.sv
// Shared definitions for the threshold-paced DMA byte FIFO.
// Assumes the threshold field holds the threshold minus one.
package dmaf_pkg;

    typedef enum logic {
        TO_DEV  = 1'b0,
        TO_HOST = 1'b1
    } dmaf_dir_e;

    // Occupancy at which a device-to-host request is raised (never below one).
    function automatic int rd_level(input logic en, input int thr, input int depth);
        int lvl;
        if (!en) begin
            lvl = 1;
        end else begin
            lvl = depth - (thr + 1);
            if (lvl < 1) lvl = 1;
        end
        return lvl;
    endfunction

    // Occupancy at or below which a host-to-device request is raised again.
    function automatic int wr_level(input logic en, input int thr);
        return en ? thr + 1 : 0;
    endfunction

endpackage

// File: rtl/dmaf_store.sv
// Circular byte store with read and write pointers and an occupancy count.
// Assumes push and pop are already qualified (no push when full, no pop
// when empty); flush has priority over both.
module dmaf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] occ_nxt
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Next occupancy, shared with the request logic.
    always_comb begin
        if (flush) occ_nxt = '0;
        else       occ_nxt = occ + CW'(push) - CW'(pop);
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
            occ <= occ_nxt;
        end
    end

    // Data storage write.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/dmaf_req.sv
// DMA request generator. Tracks whether a transfer is active and raises or
// drops the request from the next-cycle occupancy, with hysteresis that
// depends on direction and threshold. Assumes direction is stable during
// a transfer.
module dmaf_req
    import dmaf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tc,
    input  logic          fifo_en,
    input  dmaf_dir_e     dir,
    input  logic [TW-1:0] thr,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] occ_nxt,
    input  logic          sector_end,
    output logic          req
);

    logic          active_q, active_d, req_d;
    logic [CW-1:0] lvl_rd, lvl_wr;

    // Fill levels derived from the programmed threshold.
    always_comb begin
        lvl_rd = CW'(rd_level(fifo_en, int'(thr), DEPTH));
        lvl_wr = CW'(wr_level(fifo_en, int'(thr)));
    end

    // Transfer activity: terminal count beats start.
    always_comb begin
        if (tc)         active_d = 1'b0;
        else if (start) active_d = 1'b1;
        else            active_d = active_q;
    end

    // Request set/clear with hold between the two levels.
    always_comb begin
        req_d = req;
        if (!active_d) begin
            req_d = 1'b0;
        end else if (dir == TO_HOST) begin
            if (occ_nxt == '0)                        req_d = 1'b0;
            else if (occ_nxt >= lvl_rd || sector_end) req_d = 1'b1;
        end else begin
            if (occ_nxt == cap)         req_d = 1'b0;
            else if (occ_nxt <= lvl_wr) req_d = 1'b1;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            req      <= 1'b0;
        end else begin
            active_q <= active_d;
            req      <= req_d;
        end
    end

endmodule

// File: rtl/dma_fifo_ctrl.sv
// Threshold-paced DMA byte FIFO. Routes host acknowledge and device
// push/pop onto the store by direction, bounds the capacity, records
// device-side faults and drives the DMA request. Assumes the host never
// acknowledges without a request pending.
module dma_fifo_ctrl
    import dmaf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [TW-1:0] thr_cfg,
    input  logic          dir_to_host,
    input  logic          xfer_start,
    input  logic          tc,
    output logic          dma_req,
    input  logic          dma_ack,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          dev_push,
    input  logic          dev_last,
    input  logic [DW-1:0] dev_wdata,
    input  logic          dev_pop,
    output logic [DW-1:0] dev_rdata,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          xfer_err
);

    dmaf_dir_e     dir;
    logic [CW-1:0] occ, occ_nxt, cap;
    logic [DW-1:0] head, wdata;
    logic          push_req, pop_req, push_ok, pop_ok, dev_fault, sector_end;

    // Side selection and qualification of store accesses.
    always_comb begin
        dir        = dmaf_dir_e'(dir_to_host);
        cap        = fifo_en ? CW'(DEPTH) : CW'(1);
        push_req   = (dir == TO_HOST) ? dev_push  : dma_ack;
        pop_req    = (dir == TO_HOST) ? dma_ack   : dev_pop;
        wdata      = (dir == TO_HOST) ? dev_wdata : host_wdata;
        push_ok    = !xfer_start && push_req && (occ < cap);
        pop_ok     = !xfer_start && pop_req && (occ != '0);
        dev_fault  = !xfer_start && ((dir == TO_HOST) ? (dev_push && occ >= cap)
                                                       : (dev_pop && occ == '0));
        sector_end = (dir == TO_HOST) && push_ok && dev_last;
    end

    // Sticky device fault, cleared by a new transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)         xfer_err <= 1'b0;
        else if (xfer_start) xfer_err <= 1'b0;
        else if (dev_fault)  xfer_err <= 1'b1;
    end

    dmaf_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (xfer_start),
        .push    (push_ok),
        .pop     (pop_ok),
        .wdata   (wdata),
        .head    (head),
        .occ     (occ),
        .occ_nxt (occ_nxt)
    );

    dmaf_req #(.DEPTH(DEPTH)) i_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .tc         (tc),
        .fifo_en    (fifo_en),
        .dir        (dir),
        .thr        (thr_cfg),
        .cap        (cap),
        .occ_nxt    (occ_nxt),
        .sector_end (sector_end),
        .req        (dma_req)
    );

    assign host_rdata = head;
    assign dev_rdata  = head;
    assign fifo_full  = (occ == cap);
    assign fifo_empty = (occ == '0);

endmodule

// File: rtl/dmaf_chk.sv
// Property checker for dma_fifo_ctrl, attached with bind below.
module dmaf_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_to_host,
    input logic          fifo_en,
    input logic          xfer_start,
    input logic          tc,
    input logic          dma_req,
    input logic          fifo_full,
    input logic          xfer_err,
    input logic [CW-1:0] occ
);

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R5
    rd_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_to_host && $stable(dir_to_host) && dma_req) |-> (occ != '0));

    // R6
    wr_start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !tc && !dir_to_host) |=> dma_req);

    // R6
    wr_full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_to_host && $stable(dir_to_host) && $stable(fifo_en) && fifo_full) |-> !dma_req);

    // R8
    tc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !dma_req);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_err && !xfer_start) |=> xfer_err);

endmodule

bind dma_fifo_ctrl dmaf_chk #(.DEPTH(DEPTH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_to_host (dir_to_host),
    .fifo_en     (fifo_en),
    .xfer_start  (xfer_start),
    .tc          (tc),
    .dma_req     (dma_req),
    .fifo_full   (fifo_full),
    .xfer_err    (xfer_err),
    .occ         (occ)
);

// File: tb/test_dma_fifo_ctrl.sv
`timescale 1ns/1ps
// Bench for dma_fifo_ctrl: queue-based reference model compared every clock,
// plus directed point checks on request edges.
module test_dma_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [3:0] thr_cfg = 4'd0;
    logic       dir_to_host = 1'b1;
    logic       xfer_start = 1'b0;
    logic       tc = 1'b0;
    logic       dma_req;
    logic       dma_ack = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       dev_push = 1'b0;
    logic       dev_last = 1'b0;
    logic [7:0] dev_wdata = 8'h00;
    logic       dev_pop = 1'b0;
    logic [7:0] dev_rdata;
    logic       fifo_full, fifo_empty, xfer_err;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 0;
    string req_tag = "R1";

    always #4 clk = ~clk;

    dma_fifo_ctrl i_dma_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_cfg(thr_cfg),
        .dir_to_host(dir_to_host), .xfer_start(xfer_start), .tc(tc),
        .dma_req(dma_req), .dma_ack(dma_ack), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dev_push(dev_push), .dev_last(dev_last),
        .dev_wdata(dev_wdata), .dev_pop(dev_pop), .dev_rdata(dev_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .xfer_err(xfer_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model.
    logic [7:0] mq[$];
    bit m_req = 0, m_act = 0, m_err = 0;

    always @(posedge clk) begin : model
        int cap, n0, n, lr, lw;
        bit push, pop, push_ok, pop_ok, fault, send;
        if (!rst_n) begin
            mq.delete(); m_req = 0; m_act = 0; m_err = 0;
        end else begin
            cap = fifo_en ? 16 : 1;
            n0 = mq.size();
            push = dir_to_host ? dev_push : dma_ack;
            pop  = dir_to_host ? dma_ack : dev_pop;
            push_ok = !xfer_start && push && n0 < cap;
            pop_ok  = !xfer_start && pop && n0 > 0;
            fault = !xfer_start && (dir_to_host ? (dev_push && n0 >= cap) : (dev_pop && n0 == 0));
            send = dir_to_host && push_ok && dev_last;
            if (xfer_start) mq.delete();
            else begin
                if (pop_ok) void'(mq.pop_front());
                if (push_ok) mq.push_back(dir_to_host ? dev_wdata : host_wdata);
            end
            if (xfer_start) m_err = 0; else if (fault) m_err = 1;
            if (tc) m_act = 0; else if (xfer_start) m_act = 1;
            n = mq.size();
            lr = fifo_en ? 16 - (int'(thr_cfg) + 1) : 1;
            if (lr < 1) lr = 1;
            lw = fifo_en ? int'(thr_cfg) + 1 : 0;
            if (!m_act) m_req = 0;
            else if (dir_to_host) begin
                if (n == 0) m_req = 0;
                else if (n >= lr || send) m_req = 1;
            end else begin
                if (n == cap) m_req = 0;
                else if (n <= lw) m_req = 1;
            end
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin : compare
        int capn;
        if (cmp_on) begin
            capn = fifo_en ? 16 : 1;
            chk(req_tag, {7'd0, dma_req}, {7'd0, m_req});
            chk("R2 full", {7'd0, fifo_full}, {7'd0, (mq.size() == capn)});
            chk("R2 empty", {7'd0, fifo_empty}, {7'd0, (mq.size() == 0)});
            chk("R10", {7'd0, xfer_err}, {7'd0, m_err});
            if (mq.size() > 0) begin
                chk("R2 host_rdata", host_rdata, mq[0]);
                chk("R2 dev_rdata", dev_rdata, mq[0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        xfer_start = 0; tc = 0; dma_ack = 0; dev_push = 0; dev_pop = 0; dev_last = 0;
    endtask

    task automatic begin_xfer(input bit to_host, input bit en, input logic [3:0] thr);
        idle();
        dir_to_host = to_host; fifo_en = en; thr_cfg = thr; xfer_start = 1;
        tick();
        xfer_start = 0;
    endtask

    task automatic dpush(input logic [7:0] d, input bit last);
        idle(); dev_push = 1; dev_wdata = d; dev_last = last; tick(); idle();
    endtask

    task automatic hack(input logic [7:0] d);
        idle(); dma_ack = 1; host_wdata = d; tick(); idle();
    endtask

    task automatic dpop();
        idle(); dev_pop = 1; tick(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 req", {7'd0, dma_req}, 8'd0);
        chk("R1 empty", {7'd0, fifo_empty}, 8'd1);
        chk("R1 full", {7'd0, fifo_full}, 8'd0);
        chk("R1 err", {7'd0, xfer_err}, 8'd0);
        rst_n = 1;
        cmp_on = 1;
        tick();

        // R3: threshold 8 toward host, level 16-8 = 8
        req_tag = "R3";
        begin_xfer(1, 1, 4'd7);
        for (int i = 0; i < 7; i++) dpush(8'h10 + 8'(i), 0);
        chk("R3 below level", {7'd0, dma_req}, 8'd0);
        dpush(8'h17, 0);
        chk("R3 at level", {7'd0, dma_req}, 8'd1);

        // R5: holds until empty
        req_tag = "R5";
        for (int i = 0; i < 7; i++) hack(8'h00);
        chk("R5 hold", {7'd0, dma_req}, 8'd1);
        hack(8'h00);
        chk("R5 empty drop", {7'd0, dma_req}, 8'd0);

        // R4: sector end forces request
        req_tag = "R4";
        dpush(8'hA1, 0); dpush(8'hA2, 0);
        chk("R4 before last", {7'd0, dma_req}, 8'd0);
        dpush(8'hA3, 1);
        chk("R4 last byte", {7'd0, dma_req}, 8'd1);
        for (int i = 0; i < 3; i++) hack(8'h00);

        // R3: threshold 16 clamps level to one byte
        req_tag = "R3";
        thr_cfg = 4'd15;
        dpush(8'h55, 0);
        chk("R3 level one", {7'd0, dma_req}, 8'd1);
        hack(8'h00);

        // R6: host-to-device start and fill
        req_tag = "R6";
        begin_xfer(0, 1, 4'd3);
        chk("R6 start", {7'd0, dma_req}, 8'd1);
        for (int i = 0; i < 15; i++) hack(8'h30 + 8'(i));
        chk("R6 not full", {7'd0, dma_req}, 8'd1);
        hack(8'h3F);
        chk("R6 full drop", {7'd0, dma_req}, 8'd0);
        chk("R6 full flag", {7'd0, fifo_full}, 8'd1);

        // R7: reassert at thr+1 = 4 bytes left
        req_tag = "R7";
        for (int i = 0; i < 11; i++) dpop();
        chk("R7 five left", {7'd0, dma_req}, 8'd0);
        dpop();
        chk("R7 four left", {7'd0, dma_req}, 8'd1);
        for (int i = 0; i < 4; i++) dpop();

        // R10: underrun on device pop
        dpop();
        chk("R10 underrun", {7'd0, xfer_err}, 8'd1);

        // R11: start flushes and clears fault
        req_tag = "R11";
        begin_xfer(1, 1, 4'd7);
        chk("R11 err clear", {7'd0, xfer_err}, 8'd0);
        for (int i = 0; i < 5; i++) dpush(8'h60 + 8'(i), 0);
        begin_xfer(1, 1, 4'd7);
        chk("R11 flushed", {7'd0, fifo_empty}, 8'd1);

        // R10: overrun on device push
        req_tag = "R3";
        for (int i = 0; i < 16; i++) dpush(8'h70 + 8'(i), 0);
        chk("R10 no err at full", {7'd0, xfer_err}, 8'd0);
        dpush(8'hEE, 0);
        chk("R10 overrun", {7'd0, xfer_err}, 8'd1);
        chk("R10 head kept", host_rdata, 8'h70);

        // R8: terminal count
        req_tag = "R8";
        begin_xfer(0, 1, 4'd3);
        hack(8'h01); hack(8'h02);
        idle(); tc = 1; tick(); idle();
        chk("R8 tc drop", {7'd0, dma_req}, 8'd0);
        dpop(); dpop();
        chk("R8 no rerequest", {7'd0, dma_req}, 8'd0);

        // R9: single-byte mode, both directions
        req_tag = "R9";
        begin_xfer(0, 0, 4'd9);
        chk("R9 wr start", {7'd0, dma_req}, 8'd1);
        hack(8'h42);
        chk("R9 wr one byte", {7'd0, dma_req}, 8'd0);
        dpop();
        chk("R9 wr again", {7'd0, dma_req}, 8'd1);
        begin_xfer(1, 0, 4'd2);
        dpush(8'h24, 0);
        chk("R9 rd byte", {7'd0, dma_req}, 8'd1);
        hack(8'h00);
        chk("R9 rd ack drop", {7'd0, dma_req}, 8'd0);

        // Random segments under the model.
        req_tag = "R2 random";
        for (int s = 0; s < 24; s++) begin
            begin_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                       4'($urandom_range(0, 15)));
            for (int c = 0; c < 400; c++) begin
                tc         = ($urandom_range(0, 299) == 0);
                dma_ack    = 1'($urandom_range(0, 1));
                host_wdata = 8'($urandom);
                dev_push   = 1'($urandom_range(0, 1));
                dev_pop    = 1'($urandom_range(0, 1));
                dev_last   = ($urandom_range(0, 9) == 0);
                dev_wdata  = 8'($urandom);
                tick();
            end
        end
        idle();
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule